// File: doc/BRIEF.md
# Clock Rate Switch Sequencer

This block steps a system through a change of clock rate among full speed, one-half and one-thirty-second. Software first loads five delay values into a small write-only register set, then writes a one-hot rate request into a control register. That write starts a fixed handshake. The block asserts an active-low freeze output and waits for a freeze acknowledge. It then pulls a group of active-low clock-change lines low, raises a PLL-bypass output, releases the clock-change lines, drops bypass, and finally releases freeze. Each step is separated by its own programmed delay.

All delays are counted in the block's own clock, which runs at half the system rate. A delay value of N places N block clocks between two successive output events. A value of zero behaves like one. While a sequence is in progress the block reports busy and ignores any new request. When freeze is released, a rate output takes the requested ratio so that neighbouring logic can follow the active rate.

Top module: `fsx_top`

## Requirements
- R1: After reset, freeze_no is 1, every clk_chg_no line is 1, bypass_o is 0, busy_o is 0 and rate_o is 0 (full rate). All delay registers reset to 1.
- R2: The control register is at write address 0, and only its low 8 bits are used. Bit 0 requests full rate (rate code 0), bit 1 requests half rate (rate code 1) and bit 5 requests 1/32 rate (rate code 2).
- R3: A sequence starts only on a write to address 0 that finds the stored control value at zero and carries exactly one of the bits 0, 1 or 5. freeze_no goes low and busy_o goes high at that same write edge.
- R4: A control write with several bits set, or with only reserved bits (2, 3, 4, 6, 7) set, starts nothing.
- R5: Once the control register holds a nonzero value, no further request is taken until a write returns it to zero.
- R6: Control writes that arrive while busy_o is high start nothing, including after the current sequence ends.
- R7: The block waits for freeze_ack_i without limit. The clk_chg_no lines go low max(A,1) clocks after the edge that samples freeze_ack_i high, where A is the 8-bit value at address 1.
- R8: bypass_o rises max(B,1) clocks after clk_chg_no goes low, where B is the 16-bit value at address 3.
- R9: clk_chg_no returns high max(C,1) clocks after bypass_o rises, where C is the 8-bit value at address 2.
- R10: bypass_o falls max(D,1) clocks after clk_chg_no returns high, where D is the 8-bit value at address 4.
- R11: freeze_no returns high max(E,1) clocks after bypass_o falls, where E is the 32-bit value at address 5. At that same edge busy_o falls and rate_o takes the requested rate code.
- R12: Delay values wider than a few bits (16-bit and 32-bit counts above 255) are counted in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (half system rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| freeze_ack_i | input | 1 | Freeze acknowledge from the system |
| freeze_no | output | 1 | Freeze request, active low |
| clk_chg_no | output | 3 | Clock-change lines, active low, all driven together |
| bypass_o | output | 1 | PLL bypass request |
| busy_o | output | 1 | Sequence in progress |
| rate_o | output | 2 | Active rate code: 0 full, 1 half, 2 one-thirty-second |

## Verification
The assertions assume that freeze_ack_i rises only while freeze_no is low and stays high until freeze_no is released. They also assume that the register values are not rewritten during the phase that uses them. The stimulus follows both rules: it raises the acknowledge a few clocks after it sees freeze asserted and drops it only after the release. It writes delay registers only while the block is idle. The one exception is the control register, which the stimulus writes deliberately during a sequence to exercise the ignore rule.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CTRL_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_ACT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DACT = 3'd2;
  localparam logic [ADDR_W-1:0] A_ABT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DABT = 3'd4;
  localparam logic [ADDR_W-1:0] A_PST  = 3'd5;

  typedef enum logic [1:0] {
    RATE_FULL = 2'd0,
    RATE_HALF = 2'd1,
    RATE_SLOW = 2'd2
  } rate_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FRZ, ST_ACT, ST_ABT, ST_DACT, ST_DABT, ST_PST
  } state_e;

  typedef enum logic [2:0] {
    SEL_ACT, SEL_ABT, SEL_DACT, SEL_DABT, SEL_PST
  } sel_e;

  function automatic logic code_ok(logic [CTRL_W-1:0] c);
    return (c == 8'h01) || (c == 8'h02) || (c == 8'h20);
  endfunction

  function automatic rate_e code_rate(logic [CTRL_W-1:0] c);
    if (c[1]) return RATE_HALF;
    if (c[5]) return RATE_SLOW;
    return RATE_FULL;
  endfunction
endpackage

// File: rtl/fsx_regs.sv
module fsx_regs
  import fsx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic [7:0]        act_o,
  output logic [7:0]        dact_o,
  output logic [15:0]       abt_o,
  output logic [7:0]        dabt_o,
  output logic [31:0]       pst_o,
  output logic              trig_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
  // start needs a prior zero (re-arm), a legal one-hot code and an idle sequencer
  assign trig_o  = ctrl_wr && (ctrl_q == '0) && code_ok(wr_data_i[CTRL_W-1:0]) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      act_o  <= 8'd1;
      dact_o <= 8'd1;
      abt_o  <= 16'd1;
      dabt_o <= 8'd1;
      pst_o  <= 32'd1;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_CTRL:  ctrl_q <= wr_data_i[CTRL_W-1:0];
        A_ACT:   act_o  <= wr_data_i[7:0];
        A_DACT:  dact_o <= wr_data_i[7:0];
        A_ABT:   abt_o  <= wr_data_i[15:0];
        A_DABT:  dabt_o <= wr_data_i[7:0];
        A_PST:   pst_o  <= wr_data_i;
        default: ;
      endcase
    end
  end

  p_trig_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> $onehot(ctrl_q));
endmodule

// File: rtl/fsx_delay.sv
module fsx_delay #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= val_i;
    else if (!done_o)  cnt_q <= cnt_q - CNT_W'(1);
  end

  p_floor_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && done_o) |=> $stable(cnt_q));
endmodule

// File: rtl/fsx_fsm.sv
module fsx_fsm
  import fsx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [CTRL_W-1:0] code_i,
  input  logic              ack_i,
  input  logic              done_i,
  output logic              load_o,
  output sel_e              sel_o,
  output logic              freeze_o,
  output logic              chg_o,
  output logic              byp_o,
  output logic              busy_o,
  output rate_e             rate_o
);
  state_e st_q;
  rate_e  tgt_q;

  assign busy_o = (st_q != ST_IDLE);

  always_comb begin
    load_o = 1'b0;
    sel_o  = SEL_ACT;
    unique case (st_q)
      ST_FRZ:  begin load_o = ack_i;  sel_o = SEL_ACT;  end
      ST_ACT:  begin load_o = done_i; sel_o = SEL_ABT;  end
      ST_ABT:  begin load_o = done_i; sel_o = SEL_DACT; end
      ST_DACT: begin load_o = done_i; sel_o = SEL_DABT; end
      ST_DABT: begin load_o = done_i; sel_o = SEL_PST;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      tgt_q    <= RATE_FULL;
      rate_o   <= RATE_FULL;
      freeze_o <= 1'b0;
      chg_o    <= 1'b0;
      byp_o    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (trig_i) begin
          st_q     <= ST_FRZ;
          tgt_q    <= code_rate(code_i);
          freeze_o <= 1'b1;
        end
        ST_FRZ:  if (ack_i)  st_q <= ST_ACT;
        ST_ACT:  if (done_i) begin st_q <= ST_ABT;  chg_o <= 1'b1; end
        ST_ABT:  if (done_i) begin st_q <= ST_DACT; byp_o <= 1'b1; end
        ST_DACT: if (done_i) begin st_q <= ST_DABT; chg_o <= 1'b0; end
        ST_DABT: if (done_i) begin st_q <= ST_PST;  byp_o <= 1'b0; end
        ST_PST:  if (done_i) begin
          st_q     <= ST_IDLE;
          freeze_o <= 1'b0;
          rate_o   <= tgt_q;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_chg_in_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> freeze_o);
  p_byp_in_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_o |-> freeze_o);
  p_rate_on_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rate_o) |-> $fell(freeze_o));
  p_no_retrigger_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && freeze_o) |=> (freeze_o || !busy_o));
endmodule

// File: rtl/fsx_top.sv
module fsx_top
  import fsx_pkg::*;
#(
  parameter int unsigned NUM_CHG = 3,
  parameter int unsigned CNT_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [31:0]        wr_data_i,
  input  logic               freeze_ack_i,
  output logic               freeze_no,
  output logic [NUM_CHG-1:0] clk_chg_no,
  output logic               bypass_o,
  output logic               busy_o,
  output logic [1:0]         rate_o
);
  logic [7:0]       act, dact, dabt;
  logic [15:0]      abt;
  logic [31:0]      pst;
  logic             trig, load, done, frz, chg;
  sel_e             sel;
  rate_e            rate;
  logic [CNT_W-1:0] load_val;

  fsx_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .busy_i(busy_o), .act_o(act), .dact_o(dact), .abt_o(abt),
    .dabt_o(dabt), .pst_o(pst), .trig_o(trig)
  );

  always_comb begin
    unique case (sel)
      SEL_ABT:  load_val = CNT_W'(abt);
      SEL_DACT: load_val = CNT_W'(dact);
      SEL_DABT: load_val = CNT_W'(dabt);
      SEL_PST:  load_val = CNT_W'(pst);
      default:  load_val = CNT_W'(act);
    endcase
  end

  fsx_delay #(.CNT_W(CNT_W)) u_delay (
    .clk_i, .rst_ni, .load_i(load), .val_i(load_val), .done_o(done)
  );

  fsx_fsm u_fsm (
    .clk_i, .rst_ni, .trig_i(trig), .code_i(wr_data_i[CTRL_W-1:0]),
    .ack_i(freeze_ack_i), .done_i(done), .load_o(load), .sel_o(sel),
    .freeze_o(frz), .chg_o(chg), .byp_o(bypass_o), .busy_o(busy_o),
    .rate_o(rate)
  );

  assign freeze_no  = ~frz;
  assign clk_chg_no = {NUM_CHG{~chg}};
  assign rate_o     = rate;

  p_chg_lines_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_chg_no == '0) || (clk_chg_no == '1));
endmodule

// File: tb/sim_fsx_top.sv
module sim_fsx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        ack = 1'b0;
  logic        freeze_n, byp, busy;
  logic [2:0]  chg_n;
  logic [1:0]  rate;
  int          cyc = 0;
  int          n_run = 0, n_fail = 0;
  bit          ended = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fsx_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .freeze_ack_i(ack), .freeze_no(freeze_n),
    .clk_chg_no(chg_n), .bypass_o(byp), .busy_o(busy), .rate_o(rate)
  );

  task automatic chk(string req, longint act_v, longint exp_v);
    n_run++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int mx(int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic logic pick(int s);
    case (s)
      0: return freeze_n;
      1: return chg_n[0];
      default: return byp;
    endcase
  endfunction

  // returns the edge index at which the selected output changed
  task automatic wait_chg(int s, output int t);
    logic v0 = pick(s);
    t = -1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pick(s) != v0) begin t = cyc; break; end
    end
  endtask

  task automatic idle_quiet(string req, int ncyc);
    repeat (ncyc) @(negedge clk);
    chk(req, {freeze_n, busy}, 2'b10);
  endtask

  task automatic run_seq(logic [7:0] code, int a, int b, int c, int d, int e, int exp_rate);
    int s, t1, t2, t3, t4, t5;
    wr(3'd1, a); wr(3'd3, b); wr(3'd2, c); wr(3'd4, d); wr(3'd5, e);
    wr(3'd0, 0);
    wr(3'd0, code);
    chk("R3 freeze low at write edge", {freeze_n, busy}, 2'b01);
    // R6: clear and re-request while busy: ignored
    wr(3'd0, 0);
    wr(3'd0, code);
    repeat (2) @(negedge clk);
    chk("R7 waits for ack", chg_n, 3'b111);
    ack = 1'b1;
    s = cyc + 1;
    wait_chg(1, t1); chk("R7 change low delay", t1 - s, mx(a));
    chk("R7 all change lines low", chg_n, 0);
    wait_chg(2, t2); chk("R8 bypass rise delay", t2 - t1, mx(b));
    wait_chg(1, t3); chk("R9 change release delay", t3 - t2, mx(c));
    wait_chg(2, t4); chk("R10 bypass fall delay", t4 - t3, mx(d));
    wait_chg(0, t5); chk("R11 freeze release delay", t5 - t4, mx(e));
    chk("R11 busy low", busy, 0);
    chk("R2 rate code", rate, exp_rate);
    ack = 1'b0;
    idle_quiet("R6 busy write ignored", 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {freeze_n, chg_n, byp, busy, rate}, 9'b1_111_0_0_00);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: multi-bit and reserved-only writes
    wr(3'd0, 32'h03); idle_quiet("R4 multi-bit ignored", 3);
    wr(3'd0, 32'h01); idle_quiet("R5 no re-arm without zero", 3);
    wr(3'd0, 0);
    wr(3'd0, 32'h04); idle_quiet("R4 reserved bit ignored", 3);
    wr(3'd0, 0);
    wr(3'd0, 32'h21); idle_quiet("R4 two legal bits ignored", 3);
    chk("R2 rate unchanged", rate, 0);
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] code = (k == 0) ? 8'h02 : (k == 1) ? 8'h20 : 8'h01;
        int er = (k == 0) ? 1 : (k == 1) ? 2 : 0;
        run_seq(code, n, (n + 1) % 4, (n + 2) % 4, (n + 3) % 4, (n + k) % 4, er);
      end
    end
    run_seq(8'h20, 7, 300, 5, 2, 1000, 2);
    chk("R12 wide counts completed", rate, 2);
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule